// File: doc/BRIEF.md
# Parallel-Port Nibble Register Access Sequencer

This block sits on the host side of a PC-style parallel port. It performs single-register reads and writes on a disk controller that is reached through a bridge on that port. The block drives the 8-bit data lines and the 4-bit control lines, and it watches the upper status lines. An access is offered on a valid/ready request channel. It carries a direction, a space select, a register index and, for a write, a byte. The block then plays a fixed program of port updates.

Every access opens the same way. Control rests at 0x4, the bridge address byte goes onto the data lines, and a seven-step control strobe follows. A write then presents the value and toggles control through a short latch pattern. A read raises control to 0x6 and takes the status lines once as the low nibble. It returns control to 0x4 and takes the status lines again as the high nibble, then joins the two halves into one byte.

Each port update is held for a programmable number of clock cycles, which sets the pace of the cable. `busy` frames the whole access. `done` marks its end with a single-cycle pulse, and a read result stays on `rd_data` after that pulse.

Top module: `pport_nibble_regio`

## Requirements
- R1: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `busy` is low. `busy` rises on the accepting edge and stays high until the edge that raises `done`.
- R2: The address byte is the register index plus 0x08 when `req_space` is 0, or plus 0x10 when `req_space` is 1. It appears on `pp_data` from the second step of the access through the end of the strobe, and through the whole tail of a read.
- R3: The first step of every access drives `pp_ctrl` to 0x4. The second step places the address byte on `pp_data` and leaves control unchanged. Whenever the block is idle, `pp_ctrl` rests at 0x4.
- R4: Steps three to nine drive `pp_ctrl` in the order 0xC, 0xE, 0xE, 0xC, 0x4, 0x4, 0x4.
- R5: A read has three more steps, with control at 0x6, then 0x4, then 0x4. The status lines are captured at the end of the 0x6 step, and again at the end of the first 0x4 step.
- R6: `pp_status[3:0]` carries port status bits 7 down to 4. The read result is the second capture in bits 7:4 and the first capture in bits 3:0.
- R7: A write has five more steps. The value goes onto `pp_data` with control still at 0x4, and then `pp_ctrl` goes through 0x5, 0x7, 0x5, 0x4.
- R8: Each step lasts `step_hold` cycles, and a value of 0 counts as 1. The hold is captured at acceptance and later changes have no effect on that access. `done` rises S×H cycles after the accepting edge, where S is 12 for a read and 14 for a write and H is the held hold.
- R9: `done` is high for exactly one cycle, on the same edge that `busy` falls. A read loads `rd_data` on that edge. A write leaves `rd_data` unchanged.
- R10: A request offered while `busy` is high is ignored. The running program, its timing and its result are unaffected, and no second access starts when it is withdrawn.
- R11: After reset, `pp_ctrl` is 0x4 and `pp_data`, `busy`, `done` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_hold | input | HOLD_W (8) | Cycles per port update, captured at acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 0 = register file, 1 = command block |
| req_index | input | IDX_W (3) | Register index |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 8 | Last read result |
| pp_data | output | 8 | Parallel-port data lines |
| pp_ctrl | output | 4 | Parallel-port control lines |
| pp_status | input | 4 | Parallel-port status bits 7:4 |

## Verification
The tests use both spaces, the lowest and highest register indices, and hold values of 0, 1, 2 and 3. This separates the two address offsets, tests the index addition at its edges, and confirms that a zero hold acts as one. The bench's model of the bridge returns different status bytes under control 0x6 and under any other control value. Chosen nibble pairs such as 0xA/0x3 and 0xF/0x0 therefore show whether the halves are swapped, or were taken under the wrong control value. Reads and writes are interleaved so that `rd_data` can be seen holding across writes. A request raised in the middle of an access, together with a changed hold, must leave the trace and the completion cycle untouched.

// File: rtl/ppn_pkg.sv
package ppn_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 4;
  localparam int STEP_W  = 4;

  localparam int RD_STEPS = 12;
  localparam int WR_STEPS = 14;
  localparam int STROBE_FIRST = 2;
  localparam int STROBE_LAST  = 8;
  localparam int TAIL_FIRST   = 9;

  localparam logic [CTRL_W-1:0] CTL_REST  = 4'h4;
  localparam logic [CTRL_W-1:0] CTL_SAMPL = 4'h6;
  localparam logic [CTRL_W-1:0] CTL_LATA  = 4'h5;
  localparam logic [CTRL_W-1:0] CTL_LATB  = 4'h7;

  typedef struct packed {
    logic              set_ctl;
    logic [CTRL_W-1:0] ctl;
    logic              set_dat;
    logic [DATA_W-1:0] dat;
  } port_op_t;

  function automatic logic [CTRL_W-1:0] strobe_ctl(input logic [2:0] k);
    case (k)
      3'd0:    strobe_ctl = 4'hC;
      3'd1:    strobe_ctl = 4'hE;
      3'd2:    strobe_ctl = 4'hE;
      3'd3:    strobe_ctl = 4'hC;
      default: strobe_ctl = CTL_REST;
    endcase
  endfunction
endpackage

// File: rtl/ppn_step_rom.sv
module ppn_step_rom
  import ppn_pkg::*;
(
  input  logic              is_wr,
  input  logic [STEP_W-1:0] step,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output port_op_t          op
);
  logic [STEP_W-1:0] rel;
  assign rel = step - STEP_W'(STROBE_FIRST);

  always_comb begin
    op = '0;
    if (step == '0) begin
      op.set_ctl = 1'b1;
      op.ctl     = CTL_REST;
    end else if (step == STEP_W'(1)) begin
      op.set_dat = 1'b1;
      op.dat     = addr;
    end else if (step <= STEP_W'(STROBE_LAST)) begin
      op.set_ctl = 1'b1;
      op.ctl     = strobe_ctl(rel[2:0]);
    end else if (!is_wr) begin
      op.set_ctl = 1'b1;
      op.ctl     = (step == STEP_W'(TAIL_FIRST)) ? CTL_SAMPL : CTL_REST;
    end else begin
      case (step)
        STEP_W'(TAIL_FIRST):     begin op.set_dat = 1'b1; op.dat = wdata; end
        STEP_W'(TAIL_FIRST + 1): begin op.set_ctl = 1'b1; op.ctl = CTL_LATA; end
        STEP_W'(TAIL_FIRST + 2): begin op.set_ctl = 1'b1; op.ctl = CTL_LATB; end
        STEP_W'(TAIL_FIRST + 3): begin op.set_ctl = 1'b1; op.ctl = CTL_LATA; end
        default:                 begin op.set_ctl = 1'b1; op.ctl = CTL_REST; end
      endcase
    end
  end
endmodule

// File: rtl/ppn_pacer.sv
module ppn_pacer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic [HOLD_W-1:0] hold_in,
  output logic              step_end
);
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] cnt_q;

  assign step_end = active && (cnt_q == hold_q - HOLD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= HOLD_W'(1);
      cnt_q  <= '0;
    end else if (start) begin
      hold_q <= (hold_in == '0) ? HOLD_W'(1) : hold_in;
      cnt_q  <= '0;
    end else if (active) begin
      cnt_q <= step_end ? '0 : cnt_q + HOLD_W'(1);
    end
  end
endmodule

// File: rtl/ppn_nibble_join.sv
module ppn_nibble_join #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grab_lo,
  input  logic               grab_hi,
  input  logic [NIB_W-1:0]   status,
  output logic [2*NIB_W-1:0] joined
);
  logic [NIB_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (grab_lo) lo_q <= status;
      if (grab_hi) hi_q <= status;
    end
  end

  assign joined = {hi_q, lo_q};
endmodule

// File: rtl/pport_nibble_regio.sv
module pport_nibble_regio
  import ppn_pkg::*;
#(
  parameter int                HOLD_W   = 8,
  parameter int                IDX_W    = 3,
  parameter logic [DATA_W-1:0] REG_BASE = 8'h08,
  parameter logic [DATA_W-1:0] CMD_BASE = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] step_hold,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_space,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pp_data,
  output logic [CTRL_W-1:0] pp_ctrl,
  input  logic [3:0]        pp_status
);
  logic              busy_q, wr_q;
  logic [STEP_W-1:0] step_q;
  logic [DATA_W-1:0] addr_q, wd_q;

  logic              accept, step_end, last_step, advance, finish;
  logic              grab_lo, grab_hi;
  logic [DATA_W-1:0] addr_in, joined;
  logic              nx_wr;
  logic [STEP_W-1:0] nx_step;
  logic [DATA_W-1:0] nx_addr, nx_wd;
  port_op_t          nx_op;

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign accept    = req_valid && !busy_q;
  assign addr_in   = (req_space ? CMD_BASE : REG_BASE) + DATA_W'(req_index);

  assign last_step = (step_q == (wr_q ? STEP_W'(WR_STEPS - 1) : STEP_W'(RD_STEPS - 1)));
  assign advance   = busy_q && step_end && !last_step;
  assign finish    = busy_q && step_end && last_step;
  assign grab_lo   = busy_q && step_end && !wr_q && (step_q == STEP_W'(TAIL_FIRST));
  assign grab_hi   = busy_q && step_end && !wr_q && (step_q == STEP_W'(TAIL_FIRST + 1));

  assign nx_wr   = accept ? req_write : wr_q;
  assign nx_step = accept ? '0 : step_q + STEP_W'(1);
  assign nx_addr = accept ? addr_in : addr_q;
  assign nx_wd   = accept ? req_wdata : wd_q;

  ppn_step_rom u_rom (
    .is_wr (nx_wr),
    .step  (nx_step),
    .addr  (nx_addr),
    .wdata (nx_wd),
    .op    (nx_op)
  );

  ppn_pacer #(.HOLD_W(HOLD_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .active   (busy_q),
    .hold_in  (step_hold),
    .step_end (step_end)
  );

  ppn_nibble_join #(.NIB_W(4)) u_join (
    .clk     (clk),
    .rst_n   (rst_n),
    .grab_lo (grab_lo),
    .grab_hi (grab_hi),
    .status  (pp_status),
    .joined  (joined)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      step_q  <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      done    <= 1'b0;
      rd_data <= '0;
      pp_data <= '0;
      pp_ctrl <= CTL_REST;
    end else begin
      done <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        wr_q   <= req_write;
        addr_q <= addr_in;
        wd_q   <= req_wdata;
        step_q <= '0;
      end else if (advance) begin
        step_q <= nx_step;
      end else if (finish) begin
        busy_q <= 1'b0;
        if (!wr_q) rd_data <= joined;
      end
      if (accept || advance) begin
        if (nx_op.set_ctl) pp_ctrl <= nx_op.ctl;
        if (nx_op.set_dat) pp_data <= nx_op.dat;
      end
    end
  end
endmodule

// File: rtl/pport_nibble_regio_chk.sv
module pport_nibble_regio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       busy,
  input logic       done,
  input logic [3:0] pp_ctrl
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_busy_ends_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_idle_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pp_ctrl == 4'h4));

  assert_ctrl_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pp_ctrl inside {4'h4, 4'h5, 4'h6, 4'h7, 4'hC, 4'hE});

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> (busy || done));
endmodule

bind pport_nibble_regio pport_nibble_regio_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .pp_ctrl   (pp_ctrl)
);

// File: tb/pport_nibble_regio_tb.sv
module pport_nibble_regio_tb;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] step_hold;
  logic       req_valid, req_ready, req_write, req_space;
  logic [2:0] req_index;
  logic [7:0] req_wdata;
  logic       busy, done;
  logic [7:0] rd_data, pp_data;
  logic [3:0] pp_ctrl, pp_status;
  logic [7:0] st_lo, st_hi;

  always #(CLK_NS/2) clk = ~clk;

  assign pp_status = (pp_ctrl == 4'h6) ? st_lo[7:4] : st_hi[7:4];

  pport_nibble_regio u_dut (
    .clk(clk), .rst_n(rst_n), .step_hold(step_hold),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_space(req_space), .req_index(req_index), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .pp_data(pp_data), .pp_ctrl(pp_ctrl), .pp_status(pp_status)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] rd_prev = 8'h00;

  // {write, space, index[2:0], wdata, status_lo, status_hi, hold}
  localparam int NV = 6;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 8'h00, 8'hA5, 8'h3C, 8'd2},
    {1'b0, 1'b1, 3'd7, 8'h00, 8'h5F, 8'hC0, 8'd1},
    {1'b1, 1'b0, 3'd2, 8'h5A, 8'h00, 8'h00, 8'd2},
    {1'b1, 1'b1, 3'd6, 8'hC3, 8'h00, 8'h00, 8'd3},
    {1'b0, 1'b0, 3'd5, 8'h00, 8'hF0, 8'h0F, 8'd0},
    {1'b1, 1'b0, 3'd7, 8'h00, 8'h00, 8'h00, 8'd1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ctl(input bit wr, input int s);
    case (s)
      0, 1, 6, 7, 8: exp_ctl = 4'h4;
      2, 5:          exp_ctl = 4'hC;
      3, 4:          exp_ctl = 4'hE;
      default: begin
        if (!wr) exp_ctl = (s == 9) ? 4'h6 : 4'h4;
        else case (s)
          10, 12:  exp_ctl = 4'h5;
          11:      exp_ctl = 4'h7;
          default: exp_ctl = 4'h4;
        endcase
      end
    endcase
  endfunction

  function automatic string ctl_tag(input bit wr, input int s);
    if (s < 2) ctl_tag = "R3 ctrl at start";
    else if (s < 9) ctl_tag = "R4 strobe";
    else ctl_tag = wr ? "R7 write tail" : "R5 read tail";
  endfunction

  task automatic run_xact(input bit wr, input bit sp, input logic [2:0] idx,
                          input logic [7:0] wd, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] hold);
    int heff = (hold == 0) ? 1 : int'(hold);
    int ns   = wr ? 14 : 12;
    logic [7:0] addr = (sp ? 8'h10 : 8'h08) + {5'b0, idx};
    logic [7:0] exp_rd = {hi[7:4], lo[7:4]};
    @(negedge clk);
    st_lo = lo; st_hi = hi; step_hold = hold;
    req_write = wr; req_space = sp; req_index = idx; req_wdata = wd; req_valid = 1'b1;
    check(req_ready == 1'b1, "R1 ready when idle", {31'b0, req_ready}, 1);
    @(posedge clk);
    for (int c = 0; c < ns * heff; c++) begin
      int s;
      @(negedge clk);
      if (c == 0) req_valid = 1'b0;
      s = c / heff;
      check(pp_ctrl == exp_ctl(wr, s), ctl_tag(wr, s), {28'b0, pp_ctrl}, {28'b0, exp_ctl(wr, s)});
      if (s >= 1) begin
        if (wr && s >= 9) check(pp_data == wd, "R7 write value", {24'b0, pp_data}, {24'b0, wd});
        else check(pp_data == addr, "R2 address byte", {24'b0, pp_data}, {24'b0, addr});
      end
      check(busy && !done, "R1 busy until done", {30'b0, busy, done}, 32'h2);
      @(posedge clk);
    end
    @(negedge clk);
    check(done && !busy, "R8 done at S*H cycles", {30'b0, busy, done}, 32'h1);
    if (!wr) begin
      check(rd_data == exp_rd, "R6 read byte assembly", {24'b0, rd_data}, {24'b0, exp_rd});
      rd_prev = exp_rd;
    end else begin
      check(rd_data == rd_prev, "R9 rd_data held on write", {24'b0, rd_data}, {24'b0, rd_prev});
    end
    @(negedge clk);
    check(!done, "R9 done single cycle", {31'b0, done}, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_space = 1'b0;
    req_index = '0; req_wdata = '0; step_hold = 8'd2; st_lo = '0; st_hi = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(pp_ctrl == 4'h4, "R11 reset ctrl", {28'b0, pp_ctrl}, 4);
    check(pp_data == 8'h00 && rd_data == 8'h00, "R11 reset data",
          {16'b0, pp_data, rd_data}, 0);
    check(!busy && !done && req_ready, "R11 reset flags", {29'b0, busy, done, req_ready}, 1);

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v = VEC[i];
      run_xact(v[36], v[35], v[34:32], v[31:24], v[23:16], v[15:8], v[7:0]);
    end

    // R10 / R8: request and hold change while busy must not disturb the access
    fork
      run_xact(1'b0, 1'b1, 3'd3, 8'h00, 8'h96, 8'h69, 8'd2);
      begin
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_space = 1'b0;
        req_index = 3'd0; req_wdata = 8'hFF; step_hold = 8'd5;
        repeat (10) @(negedge clk);
        req_valid = 1'b0; step_hold = 8'd2;
      end
    join
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!busy && pp_ctrl == 4'h4, "R10 ignored request did not start",
            {27'b0, busy, pp_ctrl}, 32'h4);
    end
    check(rd_data == 8'h69, "R10 result unaffected", {24'b0, rd_data}, 32'h69);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule